// File: doc/BRIEF.md
# Software Flow-Control Character Detector

This block watches the stream of received characters and compares each one against four programmable flow-control codes. Two of the codes ask the local transmitter to pause, and two ask it to resume. A pause match raises a pause-detected flag and holds the transmit-pause output high. A resume match raises a resume-detected flag and drops transmit-pause.

The host reads both flags through an 8-bit status word. A status read clears the flags, so each detection is reported once. Two other blocks sit around this one: the receiver supplies a one-cycle strobe with each character, and the transmitter takes the pause output. The four code registers, the status read and detection are all gated by an enhanced-feature enable. When that enable is low, the block leaves its state alone.

Top module: `swfc_detect`

## Requirements
- R1: After reset both detect flags are 0 and `tx_pause` is 0. The pause codes reset to 0x13 and the resume codes reset to 0x11.
- R2: When `enh_en`=1, a write loads `wr_data` into the code register chosen by `wr_sel`: 0 = pause code A, 1 = pause code B, 2 = resume code A, 3 = resume code B. A character received in a later cycle is compared against the new value.
- R3: If `rx_valid`=1 and `enh_en`=1 and `rx_char` equals either pause code, the pause flag is 1 from the next clock edge on.
- R4: If `rx_valid`=1 and `enh_en`=1 and `rx_char` equals either resume code, the resume flag is 1 from the next clock edge on.
- R5: `stat_data` bit 0 is the pause flag and bit 1 is the resume flag. Bits 7..2 are 0. The whole word reads 0 while `enh_en`=0.
- R6: A `stat_rd` pulse with `enh_en`=1 clears both flags at the next edge.
- R7: If a `stat_rd` pulse and a detection of one kind happen in the same cycle, that kind's flag stays 1 and the other flag is cleared.
- R8: A pause match sets `tx_pause` at the next edge. A resume match clears it, unless a pause match happens in the same cycle.
- R9: A character that equals both a pause code and a resume code sets both flags and sets `tx_pause`.
- R10: While `enh_en`=0, writes leave the code registers unchanged, received characters detect nothing, and `stat_rd` clears nothing. `tx_pause` keeps its value.
- R11: A character that matches no code, or any `rx_char` value while `rx_valid`=0, changes no flag and leaves `tx_pause` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enh_en | input | 1 | Enhanced-feature enable |
| wr_en | input | 1 | Code register write strobe |
| wr_sel | input | 2 | Code register select |
| wr_data | input | 8 | Code value to write |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| stat_data | output | 8 | Status word |
| xon_flag | output | 1 | Resume code detected |
| xoff_flag | output | 1 | Pause code detected |
| tx_pause | output | 1 | Transmit pause request |

## Verification
The hardest cases to reach are the ones where several events land in one cycle:
- a status read in the same cycle as a detection;
- a character that equals both a pause and a resume code;
- a code write in the same cycle as a received character, which must still be compared against the old value.

None of these occurs with the reset codes and single events. The directed stimulus reprograms the registers so that one resume code equals a pause code, and then drives the read, write and receive strobes together. A long random phase then draws characters mostly from the programmed codes, and toggles the enable and the read and write strobes freely. This reaches the same coincidences in many different orders, and the reference model checks every clock.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int unsigned STAT_W = 8;

  // Packs the two flags into the status word; the whole word is zero while disabled.
  function automatic logic [STAT_W-1:0] pack_status(input logic xon, input logic xoff,
                                                    input logic en);
    logic [STAT_W-1:0] w;
    w = '0;
    w[1] = xon & en;
    w[0] = xoff & en;
    return w;
  endfunction

  // Next transmit-pause value: a pause hit dominates a resume hit in the same cycle.
  function automatic logic next_pause(input logic cur, input logic hit_on, input logic hit_off);
    if (hit_on)       return 1'b1;
    else if (hit_off) return 1'b0;
    else              return cur;
  endfunction
endpackage

// File: rtl/swfc_code_bank.sv
module swfc_code_bank #(
  parameter int unsigned CHAR_W  = 8,
  parameter int unsigned SLOTS   = 2,
  parameter logic [CHAR_W-1:0] PAUSE_INIT  = 8'h13,
  parameter logic [CHAR_W-1:0] RESUME_INIT = 8'h11,
  localparam int unsigned SEL_W = $clog2(2 * SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enh_en,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [CHAR_W-1:0]            wr_data,
  output logic [SLOTS-1:0][CHAR_W-1:0] pause_codes,
  output logic [SLOTS-1:0][CHAR_W-1:0] resume_codes
);
  logic wr_go;
  assign wr_go = wr_en & enh_en;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic ld_pause, ld_resume;
    assign ld_pause  = wr_go && (wr_sel == SEL_W'(i));
    assign ld_resume = wr_go && (wr_sel == SEL_W'(SLOTS + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pause_codes[i] <= PAUSE_INIT;
      else if (ld_pause) pause_codes[i] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         resume_codes[i] <= RESUME_INIT;
      else if (ld_resume) resume_codes[i] <= wr_data;
    end
  end
endmodule

// File: rtl/swfc_match.sv
module swfc_match #(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned SLOTS  = 2
) (
  input  logic                         enh_en,
  input  logic                         rx_valid,
  input  logic [CHAR_W-1:0]            rx_char,
  input  logic [SLOTS-1:0][CHAR_W-1:0] pause_codes,
  input  logic [SLOTS-1:0][CHAR_W-1:0] resume_codes,
  output logic                         hit_pause,
  output logic                         hit_resume
);
  logic [SLOTS-1:0] eq_pause, eq_resume;
  logic             look;

  assign look = rx_valid & enh_en;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign eq_pause[i]  = (rx_char == pause_codes[i]);
    assign eq_resume[i] = (rx_char == resume_codes[i]);
  end

  assign hit_pause  = look & (|eq_pause);
  assign hit_resume = look & (|eq_resume);
endmodule

// File: rtl/swfc_flags.sv
module swfc_flags
  import swfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enh_en,
  input  logic stat_rd,
  input  logic hit_pause,
  input  logic hit_resume,
  output logic xon_flag,
  output logic xoff_flag,
  output logic tx_pause
);
  logic rd_go;
  assign rd_go = stat_rd & enh_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xon_flag  <= 1'b0;
      xoff_flag <= 1'b0;
      tx_pause  <= 1'b0;
    end else begin
      if (hit_resume)  xon_flag <= 1'b1;
      else if (rd_go)  xon_flag <= 1'b0;
      if (hit_pause)   xoff_flag <= 1'b1;
      else if (rd_go)  xoff_flag <= 1'b0;
      tx_pause <= next_pause(tx_pause, hit_pause, hit_resume);
    end
  end

  p_xoff_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pause |=> xoff_flag);
  p_xon_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_resume |=> xon_flag);
  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !hit_pause && !hit_resume) |=> (!xoff_flag && !xon_flag));
  p_det_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && hit_pause && !hit_resume) |=> (xoff_flag && !xon_flag));
  p_pause_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pause |=> tx_pause);
  p_pause_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_resume && !hit_pause) |=> !tx_pause);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en |=> ($stable(xon_flag) && $stable(xoff_flag) && $stable(tx_pause)));
  p_no_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_pause && !hit_resume && !rd_go) |=> ($stable(xon_flag) && $stable(xoff_flag)));
endmodule

// File: rtl/swfc_detect.sv
module swfc_detect
  import swfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned SLOTS  = 2,
  parameter logic [CHAR_W-1:0] PAUSE_INIT  = 8'h13,
  parameter logic [CHAR_W-1:0] RESUME_INIT = 8'h11,
  localparam int unsigned SEL_W = $clog2(2 * SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enh_en,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_data,
  output logic              xon_flag,
  output logic              xoff_flag,
  output logic              tx_pause
);
  logic [SLOTS-1:0][CHAR_W-1:0] pause_codes, resume_codes;
  logic                         hit_pause, hit_resume;

  swfc_code_bank #(
    .CHAR_W(CHAR_W), .SLOTS(SLOTS),
    .PAUSE_INIT(PAUSE_INIT), .RESUME_INIT(RESUME_INIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .pause_codes(pause_codes), .resume_codes(resume_codes)
  );

  swfc_match #(.CHAR_W(CHAR_W), .SLOTS(SLOTS)) u_match (
    .enh_en(enh_en), .rx_valid(rx_valid), .rx_char(rx_char),
    .pause_codes(pause_codes), .resume_codes(resume_codes),
    .hit_pause(hit_pause), .hit_resume(hit_resume)
  );

  swfc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .stat_rd(stat_rd),
    .hit_pause(hit_pause), .hit_resume(hit_resume),
    .xon_flag(xon_flag), .xoff_flag(xoff_flag), .tx_pause(tx_pause)
  );

  assign stat_data = pack_status(xon_flag, xoff_flag, enh_en);

  p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pause && hit_resume) |=> (xon_flag && xoff_flag && tx_pause));
endmodule

// File: tb/swfc_detect_bench.sv
module swfc_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enh_en = 1'b0, wr_en = 1'b0, rx_valid = 1'b0, stat_rd = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0, rx_char = '0;
  logic [7:0] stat_data;
  logic       xon_flag, xoff_flag, tx_pause;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int m_code[4];   // 0,1 pause codes; 2,3 resume codes
  bit m_xon, m_xoff, m_pause;

  always #10 clk = ~clk;

  swfc_detect u_swfc_detect (
    .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rx_valid(rx_valid), .rx_char(rx_char), .stat_rd(stat_rd),
    .stat_data(stat_data), .xon_flag(xon_flag), .xoff_flag(xoff_flag),
    .tx_pause(tx_pause)
  );

  task automatic chk(input string tag, input string nm, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h at %0t", tag, nm, got, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int exp_stat;
    exp_stat = enh_en ? ((int'(m_xon) << 1) | int'(m_xoff)) : 0;
    chk(tag, "xon_flag", int'(xon_flag), int'(m_xon));
    chk(tag, "xoff_flag", int'(xoff_flag), int'(m_xoff));
    chk(tag, "tx_pause", int'(tx_pause), int'(m_pause));
    chk(tag, "stat_data", int'(stat_data), exp_stat);
  endtask

  // Apply one cycle of stimulus (called just after a falling edge), advance model, check.
  task automatic cyc(input string tag, input bit en, input bit we, input int sel,
                     input int wd, input bit rv, input int rc, input bit rd);
    bit hp, hr;
    enh_en = en; wr_en = we; wr_sel = 2'(sel); wr_data = 8'(wd);
    rx_valid = rv; rx_char = 8'(rc); stat_rd = rd;
    hp = en && rv && (rc == m_code[0] || rc == m_code[1]);
    hr = en && rv && (rc == m_code[2] || rc == m_code[3]);
    if (en && rd) begin m_xon = 0; m_xoff = 0; end
    if (hp) begin m_xoff = 1; m_pause = 1; end
    if (hr) begin m_xon = 1; if (!hp) m_pause = 0; end
    if (en && we) m_code[sel] = wd;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rx_valid = 0; stat_rd = 0;
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_code[0] = 'h13; m_code[1] = 'h13; m_code[2] = 'h11; m_code[3] = 'h11;
    m_xon = 0; m_xoff = 0; m_pause = 0;
    repeat (3) @(negedge clk);
    enh_en = 1;
    compare("R1 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after reset");
    // reset codes active
    cyc("R1 R3 R8 default pause code", 1, 0, 0, 0, 1, 'h13, 0);
    cyc("R6 read clears", 1, 0, 0, 0, 0, 0, 1);
    cyc("R1 R4 R8 default resume code", 1, 0, 0, 0, 1, 'h11, 0);
    cyc("R6 read clears resume", 1, 0, 0, 0, 0, 0, 1);
    // reprogram; first write collides with an old-code reception
    cyc("R2 write uses old code this cycle", 1, 1, 0, 'hA0, 1, 'h13, 0);
    cyc("R2 write pause B", 1, 1, 1, 'hA1, 0, 0, 1);
    cyc("R2 write resume A", 1, 1, 2, 'hB0, 0, 0, 0);
    cyc("R2 write resume B", 1, 1, 3, 'hB1, 0, 0, 0);
    cyc("R2 R11 old code no longer hits", 1, 0, 0, 0, 1, 'h13, 0);
    cyc("R3 pause code B", 1, 0, 0, 0, 1, 'hA1, 0);
    cyc("R4 R8 resume code B", 1, 0, 0, 0, 1, 'hB1, 0);
    cyc("R7 read with pause detect", 1, 0, 0, 0, 1, 'hA0, 1);
    cyc("R7 R4 read with resume detect", 1, 0, 0, 0, 1, 'hB0, 1);
    cyc("R2 resume B equals pause A", 1, 1, 3, 'hA0, 0, 0, 1);
    cyc("R9 dual match", 1, 0, 0, 0, 1, 'hA0, 0);
    cyc("R5 status packing", 1, 0, 0, 0, 0, 0, 0);
    // disabled
    cyc("R10 R5 disabled write", 0, 1, 0, 'h55, 0, 0, 0);
    cyc("R10 disabled rx", 0, 0, 0, 0, 1, 'hB0, 0);
    cyc("R10 disabled read", 0, 0, 0, 0, 0, 0, 1);
    cyc("R10 write was ignored", 1, 0, 0, 0, 1, 'h55, 0);
    cyc("R11 no valid strobe", 1, 0, 0, 0, 0, 'hB0, 0);
    cyc("R11 unmatched", 1, 0, 0, 0, 1, 'h7E, 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int pick, ch;
      pick = $urandom_range(0, 5);
      ch = (pick < 4) ? m_code[pick] : $urandom_range(0, 255);
      cyc("R3 R4 R6 R7 R8 R9 R10 random", ($urandom_range(0, 9) != 0),
          ($urandom_range(0, 15) == 0), $urandom_range(0, 3),
          ($urandom_range(0, 1) != 0) ? m_code[$urandom_range(0, 3)] : $urandom_range(0, 255),
          ($urandom_range(0, 2) != 0), ch, ($urandom_range(0, 3) == 0));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule